// File: doc/BRIEF.md
# External Bus Strobe Generator

This block turns one internal external-memory access per cycle into active-low bus strobes and a registered address. Each access comes with an address, a size flag (byte or word) and a direction flag. In the cycle after the request the block drives a read strobe and two shared strobe pins for exactly one cycle. When no request is pending, every strobe is high.

The two shared pins carry one of two encodings. In the combined style they act as a single write strobe plus a high-byte enable. In the split style they act as separate low-byte and high-byte write strobes. A bus-width input chooses an 8-bit or a 16-bit data bus. A style bit held in a small mode register selects the split style, but only on a 16-bit bus. A narrow bus always uses the combined style with the high-byte enable parked high.

The mode register is guarded by a protect register. A write to the mode register lands only while the unlock bit is set, and a successful write clears the unlock bit again. Reset returns the block to the combined style with the lock engaged.

Top module: `xbus_strobe_gen`

## Requirements
- R1: After reset the strobes `rd_n_o`, `wlo_n_o` and `whi_n_o` are high, `addr_o` is zero, the combined style is active and the unlock bit is clear.
- R2: A request sampled at a rising edge drives its strobes and address for exactly the following cycle. A cycle with no request leaves all three strobes high and `addr_o` zero.
- R3: With `bus8_i` = 1 the combined style is used whatever the style bit holds. `whi_n_o` stays high, and `wlo_n_o` is low only for writes.
- R4: In the combined style on a 16-bit bus, `wlo_n_o` is the write strobe (low for writes only) and `whi_n_o` is the high-byte enable. The enable is low when the access touches the odd byte: a byte at an odd address, or any word access.
- R5: In the split style, a write drives `wlo_n_o` low when the even byte is written (address bit 0 is 0) and `whi_n_o` low when the odd byte is written (odd byte address, or a word at any address). A word at an odd address writes only the odd byte.
- R6: A read drives `rd_n_o` low and `wlo_n_o` high. In the split style `whi_n_o` also stays high.
- R7: A write keeps `rd_n_o` high.
- R8: A register write with `reg_sel_i` = 0 targets the mode register, whose style bit is data bit 2 (1 = split). It takes effect only while the unlock bit is set. Otherwise it is ignored.
- R9: A register write with `reg_sel_i` = 1 loads the unlock bit from data bit 1. A successful mode-register write clears the unlock bit, so each style change needs a fresh unlock.
- R10: A request in the same cycle as a mode-register write uses the style held before that write. The new style applies from the next request.
- R11: `addr_o` carries the full request address, including bit 0, in every style and bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus8_i | input | 1 | Bus width select: 1 = 8-bit, 0 = 16-bit |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_sel_i | input | 1 | 0 = mode register, 1 = protect register |
| reg_wdata_i | input | REG_W | Control register write data |
| req_i | input | 1 | Access request, one access per cycle |
| req_addr_i | input | ADDR_W | Access address |
| req_word_i | input | 1 | 1 = word access, 0 = byte access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| rd_n_o | output | 1 | Read strobe, active low |
| wlo_n_o | output | 1 | Write strobe (combined) or low-byte write strobe (split), active low |
| whi_n_o | output | 1 | High-byte enable (combined) or high-byte write strobe (split), active low |
| addr_o | output | ADDR_W | Registered access address |

## Verification
The bench builds the block with `ADDR_W` = 12 and leaves the register width and bit positions at their defaults. The short address lets the vector table put a marker in the upper bits and a fixed pattern in the middle, so any bit-0 mix-up or truncation shows on `addr_o`. Because the bus-width pin can be flipped freely, every combination of style bit and bus width is reachable, including a set style bit on a narrow bus. The directed part covers the lock, relock, same-cycle and reset sequences.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

  // one set of pin levels for the three strobes, all active low
  typedef struct packed {
    logic rd_n;
    logic lo_n;
    logic hi_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{rd_n: 1'b1, lo_n: 1'b1, hi_n: 1'b1};

  // style actually in force: split only on a 16-bit bus
  function automatic logic eff_split(input logic style_bit, input logic bus8);
    return style_bit & ~bus8;
  endfunction

  // the odd byte lane is touched by an odd byte access or any word
  function automatic logic odd_lane(input logic a0, input logic word);
    return a0 | word;
  endfunction

  // the even byte lane is touched only when bit 0 is clear
  function automatic logic even_lane(input logic a0);
    return ~a0;
  endfunction

  function automatic strobe_t encode(input logic split, input logic bus8,
                                     input logic write, input logic word,
                                     input logic a0);
    strobe_t s;
    s = STROBE_IDLE;
    s.rd_n = write;
    if (bus8) begin
      s.lo_n = ~write;
      s.hi_n = 1'b1;
    end else if (!split) begin
      s.lo_n = ~write;
      s.hi_n = ~odd_lane(a0, word);
    end else if (write) begin
      s.lo_n = ~even_lane(a0);
      s.hi_n = ~odd_lane(a0, word);
    end
    return s;
  endfunction

endpackage

// File: rtl/xbs_mode_ctl.sv
module xbs_mode_ctl #(
  parameter int REG_W    = 8,
  parameter int MODE_BIT = 2,
  parameter int PROT_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic             style_q_o,
  output logic             unlock_q_o,
  output logic             mode_commit_o,
  output logic             mode_blocked_o
);
  localparam logic SEL_MODE = 1'b0;
  localparam logic SEL_PROT = 1'b1;

  logic mode_wr, prot_wr;
  logic style_q, unlock_q;
  logic unused_wdata;

  assign unused_wdata   = ^reg_wdata_i;
  assign mode_wr        = reg_wr_i && (reg_sel_i == SEL_MODE);
  assign prot_wr        = reg_wr_i && (reg_sel_i == SEL_PROT);
  assign mode_commit_o  = mode_wr && unlock_q;
  assign mode_blocked_o = mode_wr && !unlock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style_q  <= 1'b0;
      unlock_q <= 1'b0;
    end else begin
      if (mode_commit_o) begin
        style_q  <= reg_wdata_i[MODE_BIT];
        unlock_q <= 1'b0;
      end else if (prot_wr) begin
        unlock_q <= reg_wdata_i[PROT_BIT];
      end
    end
  end

  assign style_q_o  = style_q;
  assign unlock_q_o = unlock_q;
endmodule

// File: rtl/xbs_encode.sv
module xbs_encode
  import xbs_pkg::*;
(
  input  logic    style_i,
  input  logic    bus8_i,
  input  logic    req_i,
  input  logic    write_i,
  input  logic    word_i,
  input  logic    a0_i,
  output strobe_t next_o,
  output logic    split_o
);
  assign split_o = eff_split(style_i, bus8_i);

  always_comb begin
    next_o = STROBE_IDLE;
    if (req_i) next_o = encode(split_o, bus8_i, write_i, word_i, a0_i);
  end
endmodule

// File: rtl/xbs_out_stage.sv
module xbs_out_stage
  import xbs_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  strobe_t           next_i,
  input  logic [ADDR_W-1:0] addr_i,
  output strobe_t           strobe_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_o <= STROBE_IDLE;
      addr_o   <= '0;
    end else begin
      strobe_o <= next_i;
      addr_o   <= req_i ? addr_i : '0;
    end
  end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbs_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int REG_W    = 8,
  parameter int MODE_BIT = 2,
  parameter int PROT_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus8_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_word_i,
  input  logic              req_write_i,
  output logic              rd_n_o,
  output logic              wlo_n_o,
  output logic              whi_n_o,
  output logic [ADDR_W-1:0] addr_o
);
  // named internal events, observed by the bound checker
  logic    style_q, unlock_q, mode_commit, mode_blocked, split_now;
  strobe_t strobe_next, strobe_q;

  xbs_mode_ctl #(
    .REG_W(REG_W), .MODE_BIT(MODE_BIT), .PROT_BIT(PROT_BIT)
  ) u_mode (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .style_q_o(style_q), .unlock_q_o(unlock_q),
    .mode_commit_o(mode_commit), .mode_blocked_o(mode_blocked)
  );

  xbs_encode u_enc (
    .style_i(style_q), .bus8_i(bus8_i), .req_i(req_i),
    .write_i(req_write_i), .word_i(req_word_i), .a0_i(req_addr_i[0]),
    .next_o(strobe_next), .split_o(split_now)
  );

  xbs_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .next_i(strobe_next),
    .addr_i(req_addr_i), .strobe_o(strobe_q), .addr_o(addr_o)
  );

  assign rd_n_o  = strobe_q.rd_n;
  assign wlo_n_o = strobe_q.lo_n;
  assign whi_n_o = strobe_q.hi_n;
endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic bus8_i,
  input logic req_i,
  input logic req_write_i,
  input logic rd_n_o,
  input logic wlo_n_o,
  input logic whi_n_o,
  input logic style_q,
  input logic unlock_q,
  input logic mode_commit,
  input logic mode_blocked,
  input logic split_now
);
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (rd_n_o && wlo_n_o && whi_n_o));

  assert_narrow_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && bus8_i) |=> whi_n_o);

  assert_split_read_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !req_write_i && split_now) |=> (wlo_n_o && whi_n_o));

  assert_read_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !req_write_i) |=> (!rd_n_o && wlo_n_o));

  assert_write_no_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && req_write_i) |=> rd_n_o);

  assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_blocked |=> $stable(style_q));

  assert_relock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_commit |=> !unlock_q);
endmodule

bind xbus_strobe_gen xbus_strobe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus8_i(bus8_i), .req_i(req_i),
  .req_write_i(req_write_i), .rd_n_o(rd_n_o), .wlo_n_o(wlo_n_o),
  .whi_n_o(whi_n_o), .style_q(style_q), .unlock_q(unlock_q),
  .mode_commit(mode_commit), .mode_blocked(mode_blocked),
  .split_now(split_now)
);

// File: tb/xbus_strobe_gen_test.sv
module xbus_strobe_gen_test;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus8 = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic req = 1'b0, req_word = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rd_n, wlo_n, whi_n;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  xbus_strobe_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus8_i(bus8), .reg_wr_i(reg_wr),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .req_i(req),
    .req_addr_i(req_addr), .req_word_i(req_word), .req_write_i(req_write),
    .rd_n_o(rd_n), .wlo_n_o(wlo_n), .whi_n_o(whi_n), .addr_o(addr_out)
  );

  // fields: bus8, style, write, word, a0, exp rd_n, exp wlo_n, exp whi_n
  localparam logic [7:0] VEC [16] = '{
    8'b0_0_0_0_0_011, 8'b0_0_0_0_1_010, 8'b0_0_0_1_0_010, 8'b0_0_1_0_0_101,
    8'b0_0_1_0_1_100, 8'b0_0_1_1_0_100,
    8'b0_1_0_0_1_011, 8'b0_1_0_1_0_011, 8'b0_1_1_0_0_101, 8'b0_1_1_0_1_110,
    8'b0_1_1_1_0_100, 8'b0_1_1_1_1_110,
    8'b1_0_0_0_1_011, 8'b1_0_1_0_0_101, 8'b1_1_1_1_1_101, 8'b1_1_0_0_0_011
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_style(input logic s);
    reg_write(1'b1, 8'h02);
    reg_write(1'b0, {5'd0, s, 2'b00});
  endtask

  // one request; outputs are sampled at the next falling edge
  task automatic access(input logic w, input logic wd, input logic [AW-1:0] a);
    @(negedge clk);
    req = 1'b1; req_write = w; req_word = wd; req_addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic logic [2:0] pins();
    return {rd_n, wlo_n, whi_n};
  endfunction

  initial begin
    #400000;
    failures++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset strobes", 32'(pins()), 32'b111);
    check("R1 reset addr", 32'(addr_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: default style is combined (odd byte write -> enable low)
    access(1'b1, 1'b0, 12'h001);
    check("R1 default style", 32'(pins()), 32'b100);

    // vector walk over R3 R4 R5 R6 R7 R11
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      logic [AW-1:0] a;
      v = VEC[i];
      bus8 = v[7];
      set_style(v[6]);
      a = {4'(i), 7'h2B, v[3]};
      access(v[5], v[4], a);
      check($sformatf("R3/R4/R5 vec%0d strobes", i), 32'(pins()), 32'(v[2:0]));
      check($sformatf("R11 vec%0d addr", i), 32'(addr_out), 32'(a));
    end
    bus8 = 1'b0;

    // R2: exactly one cycle, then idle with zero address
    @(negedge clk);
    check("R2 idle after access", 32'(pins()), 32'b111);
    check("R2 idle addr", 32'(addr_out), 0);

    // R2: back-to-back requests, each one cycle
    set_style(1'b0);
    @(negedge clk);
    req = 1'b1; req_write = 1'b0; req_word = 1'b0; req_addr = 12'h010;
    @(negedge clk);
    check("R2 first of pair", 32'(pins()), 32'b011);
    req_write = 1'b1; req_addr = 12'h011;
    @(negedge clk);
    req = 1'b0;
    check("R2 second of pair", 32'(pins()), 32'b100);
    check("R2 second addr", 32'(addr_out), 32'h011);
    @(negedge clk);
    check("R2 idle after pair", 32'(pins()), 32'b111);

    // R8: locked mode write is ignored
    reg_write(1'b0, 8'h04);
    access(1'b1, 1'b0, 12'h001);
    check("R8 locked write ignored", 32'(pins()), 32'b100);

    // R8: unlock written with bit 1 clear keeps the lock
    reg_write(1'b1, 8'hFD);
    reg_write(1'b0, 8'h04);
    access(1'b1, 1'b0, 12'h001);
    check("R8 unlock bit clear", 32'(pins()), 32'b100);

    // R9: one write per unlock
    set_style(1'b1);
    reg_write(1'b0, 8'h00);
    access(1'b1, 1'b0, 12'h001);
    check("R9 relock after change", 32'(pins()), 32'b110);

    // R10: request in the same cycle as a committing mode write
    reg_write(1'b1, 8'h02);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h00;
    req = 1'b1; req_write = 1'b1; req_word = 1'b0; req_addr = 12'h001;
    @(negedge clk);
    reg_wr = 1'b0; req = 1'b0;
    check("R10 old style same cycle", 32'(pins()), 32'b110);
    access(1'b1, 1'b0, 12'h001);
    check("R10 new style next", 32'(pins()), 32'b100);

    // R1: reset returns to combined style
    set_style(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run strobes", 32'(pins()), 32'b111);
    rst_n = 1'b1;
    access(1'b1, 1'b0, 12'h001);
    check("R1 style after reset", 32'(pins()), 32'b100);
    reg_write(1'b0, 8'h04);
    access(1'b1, 1'b0, 12'h001);
    check("R1 lock after reset", 32'(pins()), 32'b100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule